// File: doc/BRIEF.md
# Byte-Lane Bus Parity Generator with Error Injection

This block produces odd parity, one bit per byte lane, for the address and data words that a bridge places on a processor bus. Each parity output is registered and comes with its own output-enable. This lets the pad logic drive the parity lines only while the bridge owns the matching phase of the bus.

For testing the system's parity checkers, two injection masks are provided, one for the address lanes and one for the data lanes. Each set mask bit inverts the parity of its lane. A mask acts only in cycles where its own bus is driven; in every other cycle it is ignored. The block only generates address parity and never checks it on incoming addresses, so it has no error output.

Top module: `bus_parity_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all parity outputs and both output-enables go to 0 after that edge.
- R2: When `addr_drive` and `abus_busy` are both high at an edge, `addr_par_oe` is 1 after that edge and `addr_par[i]` holds the odd parity of `addr[8i+7:8i]`: 1 when that byte has an even number of ones.
- R3: When `data_drive` is high at an edge, `data_par_oe` is 1 after that edge and `data_par[i]` holds the odd parity of `data[8i+7:8i]`, for all 8 lanes.
- R4: While the address phase is driven, a 1 in `addr_inj_mask[i]` inverts `addr_par[i]`. A 0 leaves the lane at its correct parity.
- R5: While the data phase is driven, a 1 in `data_inj_mask[i]` inverts `data_par[i]`. A 0 leaves the lane at its correct parity.
- R6: When `addr_drive` or `abus_busy` is low at an edge, `addr_par_oe` is 0 and `addr_par` is all zeros after that edge, whatever `addr_inj_mask` holds.
- R7: When `data_drive` is low at an edge, `data_par_oe` is 0 and `data_par` is all zeros after that edge, whatever `data_inj_mask` holds.
- R8: The address and data paths are independent. Driving one phase neither enables nor changes the outputs of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 32 | Outgoing address word |
| data | input | 64 | Outgoing data word |
| addr_drive | input | 1 | Bridge is sourcing the address phase |
| abus_busy | input | 1 | Address bus busy strobe |
| data_drive | input | 1 | Bridge is sourcing the data phase |
| addr_inj_mask | input | 4 | Per-lane address parity inversion mask |
| data_inj_mask | input | 8 | Per-lane data parity inversion mask |
| addr_par | output | 4 | Registered address parity lines |
| addr_par_oe | output | 1 | Output enable for the address parity lines |
| data_par | output | 8 | Registered data parity lines |
| data_par_oe | output | 1 | Output enable for the data parity lines |

## Verification
The assertions watch the enable timing and the quiet state on every cycle. An enable follows its qualifying drive condition one edge later, a disabled bus always shows zero parity, and each path tracks only its own qualifier. Whether each lane's parity value is correct, and whether an injection mask inverts exactly the chosen lanes, can only be shown by the bench. The bench sweeps all 256 byte values through every lane and a spread of mask and drive combinations, and it computes the expected parity from ones counts.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  localparam int LANE_BITS = 8;

  // odd parity bit for one lane: set when the lane holds an even count of ones
  function automatic logic odd_bit(input logic [LANE_BITS-1:0] b);
    return ~(^b);
  endfunction
endpackage

// File: rtl/lane_parity.sv
module lane_parity #(
  parameter int WIDTH  = 32,
  parameter int LANE_W = bpg_pkg::LANE_BITS
) (
  input  logic [WIDTH-1:0]        word,
  input  logic [WIDTH/LANE_W-1:0] inj_mask,
  input  logic                    active,
  output logic [WIDTH/LANE_W-1:0] par
);
  localparam int LANES = WIDTH / LANE_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] lane_bits;
    assign lane_bits = word[i*LANE_W +: LANE_W];
    // the mask is gated by the drive qualifier so it is inert when idle
    assign par[i] = ~(^lane_bits) ^ (inj_mask[i] & active);
  end
endmodule

// File: rtl/par_stage.sv
module par_stage #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [LANES-1:0] par_in,
  output logic [LANES-1:0] par_q,
  output logic             oe_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      par_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= active;
      par_q <= active ? par_in : '0;
    end
  end

  // R6, R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_q |-> (par_q == '0));

  // R2, R3
  oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    active |=> oe_q);

  // R6, R7
  oe_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> !oe_q);
endmodule

// File: rtl/bus_parity_gen.sv
module bus_parity_gen #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int LANE_W = bpg_pkg::LANE_BITS,
  localparam int A_LANES = ADDR_W / LANE_W,
  localparam int D_LANES = DATA_W / LANE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  data,
  input  logic               addr_drive,
  input  logic               abus_busy,
  input  logic               data_drive,
  input  logic [A_LANES-1:0] addr_inj_mask,
  input  logic [D_LANES-1:0] data_inj_mask,
  output logic [A_LANES-1:0] addr_par,
  output logic               addr_par_oe,
  output logic [D_LANES-1:0] data_par,
  output logic               data_par_oe
);
  logic               a_active, d_active;
  logic [A_LANES-1:0] a_par_c;
  logic [D_LANES-1:0] d_par_c;

  assign a_active = addr_drive & abus_busy;
  assign d_active = data_drive;

  lane_parity #(.WIDTH(ADDR_W), .LANE_W(LANE_W)) u_addr_lanes (
    .word(addr), .inj_mask(addr_inj_mask), .active(a_active), .par(a_par_c));

  lane_parity #(.WIDTH(DATA_W), .LANE_W(LANE_W)) u_data_lanes (
    .word(data), .inj_mask(data_inj_mask), .active(d_active), .par(d_par_c));

  par_stage #(.LANES(A_LANES)) u_addr_stage (
    .clk(clk), .rst(rst), .active(a_active), .par_in(a_par_c),
    .par_q(addr_par), .oe_q(addr_par_oe));

  par_stage #(.LANES(D_LANES)) u_data_stage (
    .clk(clk), .rst(rst), .active(d_active), .par_in(d_par_c),
    .par_q(data_par), .oe_q(data_par_oe));

  // R8
  addr_indep_chk: assert property (@(posedge clk) disable iff (rst)
    (data_drive && !(addr_drive && abus_busy)) |=> !addr_par_oe);

  // R8
  data_indep_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_drive && abus_busy && !data_drive) |=> !data_par_oe);

  // R2
  busy_needed_chk: assert property (@(posedge clk) disable iff (rst)
    addr_par_oe |-> $past(abus_busy));
endmodule

// File: tb/bus_parity_gen_tb.sv
module bus_parity_gen_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] addr;
  logic [63:0] data;
  logic        addr_drive, abus_busy, data_drive;
  logic [3:0]  addr_inj_mask;
  logic [7:0]  data_inj_mask;
  logic [3:0]  addr_par;
  logic        addr_par_oe;
  logic [7:0]  data_par;
  logic        data_par_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bus_parity_gen u_dut (
    .clk(clk), .rst(rst), .addr(addr), .data(data),
    .addr_drive(addr_drive), .abus_busy(abus_busy), .data_drive(data_drive),
    .addr_inj_mask(addr_inj_mask), .data_inj_mask(data_inj_mask),
    .addr_par(addr_par), .addr_par_oe(addr_par_oe),
    .data_par(data_par), .data_par_oe(data_par_oe));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_par(input logic [63:0] w, input int lanes,
                                         input logic [7:0] m, input logic act);
    logic [7:0] r = '0;
    if (act)
      for (int i = 0; i < lanes; i++)
        r[i] = (($countones(w[i*8 +: 8]) % 2) == 0) ^ m[i];
    return r;
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; addr = '1; data = '1;
    addr_drive = 1'b1; abus_busy = 1'b1; data_drive = 1'b1;
    addr_inj_mask = '1; data_inj_mask = '1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 addr_par", addr_par, 0);
    chk("R1 addr_par_oe", addr_par_oe, 0);
    chk("R1 data_par", data_par, 0);
    chk("R1 data_par_oe", data_par_oe, 0);
    rst = 1'b0;

    for (int v = 0; v < 1024; v++) begin
      logic [7:0] b;
      logic       a_on, d_on;
      logic [3:0] am;
      logic [7:0] dm;
      b = v[7:0];
      addr = {b, ~b, b + 8'd1, b * 8'd3};
      data = {b, b ^ 8'h5A, b + 8'd7, ~b, b * 8'd5, b ^ 8'hC3, b - 8'd1, {b[3:0], b[7:4]}};
      addr_drive = (v % 4) != 0;
      abus_busy  = (v % 4) != 1;
      data_drive = (v % 3) != 0;
      am = (v < 256) ? 4'h0 : v[11:8] ^ b[3:0];
      dm = (v < 256) ? 8'h00 : b ^ 8'hA5 ^ v[9:8];
      addr_inj_mask = am;
      data_inj_mask = dm;
      a_on = addr_drive & abus_busy;
      d_on = data_drive;
      @(negedge clk);
      if (a_on) begin
        chk(am == 0 ? "R2 addr_par" : "R4 addr_par", addr_par,
            exp_par({32'h0, addr}, 4, {4'h0, am}, 1'b1));
        chk("R2 addr_par_oe", addr_par_oe, 1);
      end else begin
        chk("R6 addr_par", addr_par, 0);
        chk("R6 addr_par_oe", addr_par_oe, 0);
      end
      if (d_on) begin
        chk(dm == 0 ? "R3 data_par" : "R5 data_par", data_par,
            exp_par(data, 8, dm, 1'b1));
        chk("R3 data_par_oe", data_par_oe, 1);
      end else begin
        chk("R7 data_par", data_par, 0);
        chk("R7 data_par_oe", data_par_oe, 0);
      end
      if (a_on != d_on)
        chk("R8 independent enables", {addr_par_oe, data_par_oe}, {a_on, d_on});
    end

    // R4 single-lane inversions on a fixed address
    for (int i = 0; i < 4; i++) begin
      addr = 32'h0103_0F00; addr_drive = 1'b1; abus_busy = 1'b1;
      addr_inj_mask = 4'b1 << i;
      @(negedge clk);
      chk("R4 single lane", addr_par, exp_par(64'h0103_0F00, 4, 8'h1 << i, 1'b1));
    end
    // R5 single-lane inversions on all-zero data
    for (int i = 0; i < 8; i++) begin
      data = '0; data_drive = 1'b1; data_inj_mask = 8'h1 << i;
      @(negedge clk);
      chk("R5 single lane", data_par, 8'hFF ^ (8'h1 << i));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule